// File: doc/BRIEF.md
# Excess-One Carry-Select Adder

This block is a purely combinational 16-bit adder. It takes two unsigned operands and a carry-in, and returns a 16-bit sum with a carry-out. The operand bits are split into groups that grow in width from the least significant end: 2, 2, 3, 4 and 5 bits. The lowest group is a plain ripple adder fed by the external carry-in.

Every upper group uses a single ripple adder that assumes its incoming carry is zero. An increment-by-one converter is applied to that adder's {carry, sum}, giving the result for an incoming carry of one. A two-way selector, steered by the real carry from the group below, picks one of the two results. The group's carry-out comes from the same selector. This keeps the long carry path to one selector per group, and it avoids a second ripple adder in each group.

The block has no clock and no state. It drops straight into an ALU or multiplier datapath wherever a 16-bit add with carry-in is needed.

Top module: `esel_csa_adder`

## Requirements
- R1: `{cout, sum}` equals the 17-bit unsigned value `a + b + cin` for every input combination, and all-zero inputs give an all-zero output.
- R2: Groups cover bits [1:0], [3:2], [6:4], [10:7] and [15:11]. A carry produced inside any group reaches the next group: an operand whose bits below a boundary are all ones, plus 1, clears those bits and sets the bit at the boundary. The boundaries are at bits 2, 4, 7 and 11.
- R3: The external `cin` enters only the lowest group, so `a = b = 0` with `cin = 1` gives `sum = 1` and `cout = 0`.
- R4: When the carry into an upper group is 0, that group's sum bits equal the plain sum of its operand fields, and any overflow goes only to the next group.
- R5: When the carry into an upper group is 1 and that group's zero-carry sum is all ones, the group's sum bits become zero and it passes a carry on. For example, `a = 16'hFFFF`, `b = 0`, `cin = 1` gives `sum = 0` and `cout = 1`.
- R6: All-ones operands with `cin = 1` give `sum = 16'hFFFF` and `cout = 1`. The same operands with `cin = 0` give `sum = 16'hFFFE` and `cout = 1`.
- R7: The outputs follow the inputs combinationally, with no clock edge between an input change and the matching output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First unsigned operand |
| b | input | 16 | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The bench pushes a carry across each group boundary in turn, using operands whose low bits are all ones plus a single one. A design with a mis-sized group, or with a selector wired to the wrong carry, would then drop or misplace the bit at that boundary.

Fully propagating words with `cin = 1` exercise the excess-one path in every group at once. A converter that ignores its top bit would lose the final carry and return zero instead of a carry-out.

Patterns that only generate carries, with no propagation, check that the zero-carry path passes through untouched. Seeded random vectors then cover the mixed cases.

// File: rtl/esel_pkg.sv
package esel_pkg;

  // width of the lowest group; each later group is one bit wider than the one before,
  // except group 1, which matches group 0
  localparam int BASE_W = 2;

  function automatic int grp_width(input int k);
    return (k == 0) ? BASE_W : BASE_W + k - 1;
  endfunction

  function automatic int grp_lo(input int k);
    int lo;
    lo = 0;
    for (int i = 0; i < k; i++) lo += grp_width(i);
    return lo;
  endfunction

  function automatic int grp_count(input int width);
    int n;
    n = 0;
    while (grp_lo(n) < width) n++;
    return n;
  endfunction

  // actual width of group k once the top group is clipped to the word
  function automatic int grp_fit(input int k, input int width);
    int rest;
    rest = width - grp_lo(k);
    return (grp_width(k) < rest) ? grp_width(k) : rest;
  endfunction

endpackage

// File: rtl/esel_rca.sv
module esel_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign co = c[W];

  always_comb begin
    // R4
    rca_sum_chk: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
      else $error("ripple adder result mismatch");
  end
endmodule

// File: rtl/esel_bec.sv
module esel_bec #(
  parameter int W = 4
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // running AND of all lower bits: a bit flips when every bit below it is one
  logic [W-1:0] low_all;
  assign low_all[0] = 1'b1;
  assign dout[0]    = ~din[0];

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign low_all[i] = low_all[i-1] & din[i-1];
    assign dout[i]    = din[i] ^ low_all[i];
  end

  always_comb begin
    // R5
    bec_inc_chk: assert (dout == W'(din + 1'b1))
      else $error("excess-one converter mismatch");
  end
endmodule

// File: rtl/esel_group.sv
module esel_group #(
  parameter int W      = 4,
  parameter bit SELECT = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  if (SELECT) begin : g_sel
    logic [W-1:0] s_zero;
    logic         co_zero;
    logic [W:0]   plus_one;

    esel_rca #(.W(W)) u_rca (
      .a (a),
      .b (b),
      .ci(1'b0),
      .s (s_zero),
      .co(co_zero)
    );

    // the zero-carry carry-out sits on top so the converter also yields the carry
    esel_bec #(.W(W + 1)) u_bec (
      .din ({co_zero, s_zero}),
      .dout(plus_one)
    );

    assign {co, s} = ci ? plus_one : {co_zero, s_zero};
  end else begin : g_plain
    esel_rca #(.W(W)) u_rca (
      .a (a),
      .b (b),
      .ci(ci),
      .s (s),
      .co(co)
    );
  end

  always_comb begin
    // R4
    grp_sum_chk: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
      else $error("group result mismatch");
  end
endmodule

// File: rtl/esel_csa_adder.sv
module esel_csa_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import esel_pkg::*;

  localparam int NG = grp_count(WIDTH);

  // carry entering each group; grp_carry[NG] is the word carry-out
  logic [NG:0] grp_carry;
  assign grp_carry[0] = cin;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int LO = grp_lo(k);
    localparam int GW = grp_fit(k, WIDTH);
    localparam bit SEL = (k > 0);

    esel_group #(.W(GW), .SELECT(SEL)) u_grp (
      .a (a[LO +: GW]),
      .b (b[LO +: GW]),
      .ci(grp_carry[k]),
      .s (sum[LO +: GW]),
      .co(grp_carry[k+1])
    );

    if (k > 0) begin : g_chain
      localparam logic [WIDTH:0] LMASK = (WIDTH + 1)'((64'd1 << LO) - 64'd1);
      logic [WIDTH:0] low_sum;
      assign low_sum = ({1'b0, a} & LMASK) + ({1'b0, b} & LMASK) + {{WIDTH{1'b0}}, cin};
      always_comb begin
        // R2
        chain_chk: assert (low_sum[LO] == grp_carry[k])
          else $error("carry into group %0d is wrong", k);
      end
    end
  end

  assign cout = grp_carry[NG];

  always_comb begin
    // R1
    top_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("adder result mismatch");
  end
endmodule

// File: tb/esel_csa_adder_tb.sv
module esel_csa_adder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int exp_q[$];

  esel_csa_adder u_dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(input string tag, input int expv);
    int got;
    got = {15'd0, cout, sum};
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: a=%h b=%h cin=%0d got=%h expected=%h", tag, a, b, cin, got, expv);
    end
  endtask

  // drive after the rising edge, check at the falling edge against the model
  task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc,
                       input string tag);
    @(posedge clk);
    #1;
    a = va; b = vb; cin = vc;
    exp_q.push_back(int'(va) + int'(vb) + int'(vc));
    @(negedge clk);
    compare(tag, exp_q.pop_front());
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: got=expired expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int bnd[4] = '{2, 4, 7, 11};
    @(negedge clk);
    // R1 idle state with zero inputs
    compare("R1", 0);

    // R3 carry-in alone
    apply(16'h0000, 16'h0000, 1'b1, "R3");

    // R2 carry into each group boundary
    foreach (bnd[i]) begin
      int m;
      m = (1 << bnd[i]) - 1;
      apply(16'(m), 16'h0001, 1'b0, "R2");
      apply(16'(m), 16'h0000, 1'b1, "R2");
      apply(16'(m), 16'(m), 1'b1, "R2");
    end

    // R4 generate-only patterns, zero carry into every group
    apply(16'h0842, 16'h0421, 1'b0, "R4");
    apply(16'h1111, 16'h2222, 1'b0, "R4");
    apply(16'h8000, 16'h8000, 1'b0, "R4");

    // R5 full propagation through the excess-one paths
    apply(16'hFFFF, 16'h0000, 1'b1, "R5");
    apply(16'hAAAA, 16'h5555, 1'b1, "R5");
    apply(16'h0000, 16'hFFFF, 1'b1, "R5");

    // R6 all-ones operands
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R6");
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R6");

    // R7 output settles without any clock edge
    @(posedge clk);
    #1;
    a = 16'h1234; b = 16'h4321; cin = 1'b1;
    #1;
    compare("R7", 32'h1234 + 32'h4321 + 1);
    a = 16'h7FFF; b = 16'h0001; cin = 1'b0;
    #1;
    compare("R7", 32'h8000);

    // R1 random vectors
    void'($urandom(32'h5eed));
    for (int i = 0; i < 2000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule